// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Control

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Every cycle it looks at the register indices, write enables and instruction-class flags of the instructions in the decode, execute, memory and write-back stages, and at the jump-or-taken-branch flag that execute resolves. From these it decides what each pipeline register does on the next edge, and where each execute operand comes from.

Two events disturb the flow. The first is a load in execute whose destination is read by the instruction in decode. In that case the fetch address and the decode register hold their contents, and execute receives an empty slot. The second is a jump or taken branch resolved in execute. In that case the fetch address takes the target, and both the decode and execute registers are cleared. If both events occur in the same cycle, the redirect wins.

Forwarding selects are produced separately for the two execute operands. The newer result in the memory stage is preferred over the write-back result, and register zero is never forwarded. The controller is purely combinational and sits beside the datapath. Its outputs drive the enable and clear inputs of the pipeline registers and the operand multiplexers.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A load-use stall is detected when all of the following hold: `ex_load_i` and `ex_wen_i` are 1; `ex_rd_i` is nonzero; and `ex_rd_i` equals `dec_rs1_i` with `dec_use1_i`=1, or equals `dec_rs2_i` with `dec_use2_i`=1.
- R2: During a stall without a redirect, `pc_ctl_o` and `dec_ctl_o` are 1 (hold), and `ex_ctl_o` is 2 (insert empty slot).
- R3: When `ex_redirect_i` is 1, `pc_ctl_o`, `dec_ctl_o` and `ex_ctl_o` are all 3. For the fetch register, 3 means load the target; for the other two it means clear.
- R4: When a stall and a redirect occur together, the redirect codes of R3 apply.
- R5: With neither stall nor redirect, `pc_ctl_o`, `dec_ctl_o` and `ex_ctl_o` are 0 (advance normally).
- R6: `mem_ctl_o` and `wb_ctl_o` are always 0, whatever the stall and redirect conditions.
- R7: An operand select is 1 (memory-stage result) when `mem_wen_i` is 1, `mem_rd_i` is nonzero, and `mem_rd_i` equals that operand's source index.
- R8: An operand select is 2 (write-back result) when `wb_wen_i` is 1, `wb_rd_i` is nonzero, `wb_rd_i` equals the source index, and R7 does not apply. Otherwise the select is 0 (register file).
- R9: When both the memory and write-back stages write the register an operand needs, the select is 1.
- R10: Register index 0 never produces a forwarding select other than 0 and never raises a stall.
- R11: `fwd1_o` depends only on `ex_rs1_i`, and `fwd2_o` depends only on `ex_rs2_i`. A stage whose write enable is 0 is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1_i | input | ADDR_W | first source index of the decode instruction |
| dec_rs2_i | input | ADDR_W | second source index of the decode instruction |
| dec_use1_i | input | 1 | decode instruction reads its first source |
| dec_use2_i | input | 1 | decode instruction reads its second source |
| ex_rs1_i | input | ADDR_W | first source index in execute |
| ex_rs2_i | input | ADDR_W | second source index in execute |
| ex_rd_i | input | ADDR_W | destination index in execute |
| ex_wen_i | input | 1 | execute instruction writes a register |
| ex_load_i | input | 1 | execute instruction is a load |
| ex_redirect_i | input | 1 | jump or taken branch resolved in execute |
| mem_rd_i | input | ADDR_W | destination index in memory stage |
| mem_wen_i | input | 1 | memory-stage instruction writes a register |
| wb_rd_i | input | ADDR_W | destination index in write-back |
| wb_wen_i | input | 1 | write-back instruction writes a register |
| pc_ctl_o | output | 2 | fetch address register action |
| dec_ctl_o | output | 2 | decode register action |
| ex_ctl_o | output | 2 | execute register action |
| mem_ctl_o | output | 2 | memory register action |
| wb_ctl_o | output | 2 | write-back register action |
| fwd1_o | output | 2 | source select for first execute operand |
| fwd2_o | output | 2 | source select for second execute operand |

## Verification
The bench builds the controller with the default `ADDR_W` of 5, which gives 32 architectural registers. That width reaches both ends of the index range: register 0 exercises the never-forward and never-stall rule, and register 31 confirms that full-width comparisons are correct. With the small default, every priority collision can be set up directly: memory against write-back on one operand, different sources on the two operands, and stall against redirect.

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] dec_rs1_i,
  input  logic [ADDR_W-1:0] dec_rs2_i,
  input  logic              dec_use1_i,
  input  logic              dec_use2_i,
  input  logic [ADDR_W-1:0] ex_rs1_i,
  input  logic [ADDR_W-1:0] ex_rs2_i,
  input  logic [ADDR_W-1:0] ex_rd_i,
  input  logic              ex_wen_i,
  input  logic              ex_load_i,
  input  logic              ex_redirect_i,
  input  logic [ADDR_W-1:0] mem_rd_i,
  input  logic              mem_wen_i,
  input  logic [ADDR_W-1:0] wb_rd_i,
  input  logic              wb_wen_i,
  output logic [1:0]        pc_ctl_o,
  output logic [1:0]        dec_ctl_o,
  output logic [1:0]        ex_ctl_o,
  output logic [1:0]        mem_ctl_o,
  output logic [1:0]        wb_ctl_o,
  output logic [1:0]        fwd1_o,
  output logic [1:0]        fwd2_o
);

  localparam logic [1:0] CTL_RUN   = 2'd0;
  localparam logic [1:0] CTL_HOLD  = 2'd1;
  localparam logic [1:0] CTL_EMPTY = 2'd2;
  localparam logic [1:0] CTL_CLEAR = 2'd3;
  localparam logic [1:0] SRC_RF    = 2'd0;
  localparam logic [1:0] SRC_MEM   = 2'd1;
  localparam logic [1:0] SRC_WB    = 2'd2;
  localparam logic [ADDR_W-1:0] ZERO_REG = '0;

  logic ld_dest_live;
  logic hit1, hit2;
  logic stall;
  logic mem_live, wb_live;

  assign ld_dest_live = ex_load_i && ex_wen_i && (ex_rd_i != ZERO_REG);
  assign hit1  = dec_use1_i && (dec_rs1_i == ex_rd_i);
  assign hit2  = dec_use2_i && (dec_rs2_i == ex_rd_i);
  assign stall = ld_dest_live && (hit1 || hit2);

  always_comb begin
    if (ex_redirect_i) begin
      pc_ctl_o  = CTL_CLEAR;
      dec_ctl_o = CTL_CLEAR;
      ex_ctl_o  = CTL_CLEAR;
    end else if (stall) begin
      pc_ctl_o  = CTL_HOLD;
      dec_ctl_o = CTL_HOLD;
      ex_ctl_o  = CTL_EMPTY;
    end else begin
      pc_ctl_o  = CTL_RUN;
      dec_ctl_o = CTL_RUN;
      ex_ctl_o  = CTL_RUN;
    end
  end

  assign mem_ctl_o = CTL_RUN;
  assign wb_ctl_o  = CTL_RUN;

  assign mem_live = mem_wen_i && (mem_rd_i != ZERO_REG);
  assign wb_live  = wb_wen_i && (wb_rd_i != ZERO_REG);

  function automatic logic [1:0] pick_src(input logic [ADDR_W-1:0] rs,
                                          input logic m_ok, input logic [ADDR_W-1:0] m_rd,
                                          input logic w_ok, input logic [ADDR_W-1:0] w_rd);
    if (m_ok && (m_rd == rs))      return SRC_MEM;
    else if (w_ok && (w_rd == rs)) return SRC_WB;
    else                           return SRC_RF;
  endfunction

  assign fwd1_o = pick_src(ex_rs1_i, mem_live, mem_rd_i, wb_live, wb_rd_i);
  assign fwd2_o = pick_src(ex_rs2_i, mem_live, mem_rd_i, wb_live, wb_rd_i);

  always_comb begin
    if (ex_rd_i == ZERO_REG)
      AST_ZERO_NO_STALL: assert (pc_ctl_o != CTL_HOLD && ex_ctl_o != CTL_EMPTY); // R10
    if (ex_redirect_i)
      AST_REDIRECT_CLEARS: assert (pc_ctl_o == CTL_CLEAR && dec_ctl_o == CTL_CLEAR && ex_ctl_o == CTL_CLEAR); // R4
    if (ex_ctl_o == CTL_EMPTY)
      AST_EMPTY_WITH_HOLD: assert (pc_ctl_o == CTL_HOLD && dec_ctl_o == CTL_HOLD && ex_load_i); // R2
    if (fwd1_o == SRC_MEM)
      AST_MEM_SRC1_VALID: assert (mem_wen_i && mem_rd_i == ex_rs1_i && ex_rs1_i != ZERO_REG); // R7
    if (fwd2_o == SRC_WB)
      AST_WB_SRC2_VALID: assert (wb_wen_i && wb_rd_i == ex_rs2_i && !(mem_wen_i && mem_rd_i == ex_rs2_i)); // R9
    if (ex_rs1_i == ZERO_REG)
      AST_ZERO_NO_FWD: assert (fwd1_o == SRC_RF); // R10
  end

endmodule

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;
  localparam int AW = 5;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [AW-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic dec_use1, dec_use2, ex_wen, ex_load, ex_redir, mem_wen, wb_wen;
  logic [1:0] pc_ctl, dec_ctl, ex_ctl, mem_ctl, wb_ctl, fwd1, fwd2;
  int errors = 0, checks = 0;
  bit done = 0;

  pipe_hazard_ctrl #(.ADDR_W(AW)) i_pipe_hazard_ctrl (
    .dec_rs1_i(dec_rs1), .dec_rs2_i(dec_rs2), .dec_use1_i(dec_use1), .dec_use2_i(dec_use2),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_wen_i(ex_wen),
    .ex_load_i(ex_load), .ex_redirect_i(ex_redir), .mem_rd_i(mem_rd), .mem_wen_i(mem_wen),
    .wb_rd_i(wb_rd), .wb_wen_i(wb_wen), .pc_ctl_o(pc_ctl), .dec_ctl_o(dec_ctl),
    .ex_ctl_o(ex_ctl), .mem_ctl_o(mem_ctl), .wb_ctl_o(wb_ctl), .fwd1_o(fwd1), .fwd2_o(fwd2));

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    dec_rs1 = 0; dec_rs2 = 0; dec_use1 = 0; dec_use2 = 0;
    ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wen = 0; ex_load = 0; ex_redir = 0;
    mem_rd = 0; mem_wen = 0; wb_rd = 0; wb_wen = 0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic ctl3(input string req, input logic [1:0] p, input logic [1:0] d, input logic [1:0] e);
    chk(req, pc_ctl, p); chk(req, dec_ctl, d); chk(req, ex_ctl, e);
    chk("R6", mem_ctl, 2'd0); chk("R6", wb_ctl, 2'd0);
  endtask

  task automatic t_idle();
    idle(); settle();
    ctl3("R5", 0, 0, 0); chk("R8", fwd1, 0); chk("R8", fwd2, 0);
  endtask

  task automatic t_stall();
    idle(); ex_load = 1; ex_wen = 1; ex_rd = 7; dec_rs1 = 7; dec_use1 = 1; settle();
    ctl3("R2", 1, 1, 2);
    idle(); ex_load = 1; ex_wen = 1; ex_rd = 31; dec_rs2 = 31; dec_use2 = 1; dec_rs1 = 4; dec_use1 = 1; settle();
    ctl3("R1", 1, 1, 2);
    idle(); ex_load = 1; ex_wen = 1; ex_rd = 9; dec_rs2 = 9; dec_use2 = 0; settle();
    ctl3("R1", 0, 0, 0);
    idle(); ex_load = 0; ex_wen = 1; ex_rd = 9; dec_rs1 = 9; dec_use1 = 1; settle();
    ctl3("R1", 0, 0, 0);
    idle(); ex_load = 1; ex_wen = 1; ex_rd = 0; dec_rs1 = 0; dec_use1 = 1; settle();
    ctl3("R10", 0, 0, 0);
  endtask

  task automatic t_redirect();
    idle(); ex_redir = 1; settle();
    ctl3("R3", 3, 3, 3);
    idle(); ex_redir = 1; ex_load = 1; ex_wen = 1; ex_rd = 5; dec_rs1 = 5; dec_use1 = 1; settle();
    ctl3("R4", 3, 3, 3);
  endtask

  task automatic t_forward();
    idle(); ex_rs1 = 3; ex_rs2 = 6; mem_wen = 1; mem_rd = 3; wb_wen = 1; wb_rd = 6; settle();
    chk("R7", fwd1, 1); chk("R11", fwd2, 2);
    idle(); ex_rs1 = 12; ex_rs2 = 12; mem_wen = 1; mem_rd = 12; wb_wen = 1; wb_rd = 12; settle();
    chk("R9", fwd1, 1); chk("R9", fwd2, 1);
    idle(); ex_rs1 = 12; mem_wen = 0; mem_rd = 12; wb_wen = 1; wb_rd = 12; settle();
    chk("R8", fwd1, 2);
    idle(); ex_rs1 = 12; ex_rs2 = 12; mem_wen = 0; mem_rd = 12; wb_wen = 0; wb_rd = 12; settle();
    chk("R11", fwd1, 0); chk("R11", fwd2, 0);
    idle(); ex_rs1 = 0; ex_rs2 = 0; mem_wen = 1; mem_rd = 0; wb_wen = 1; wb_rd = 0; settle();
    chk("R10", fwd1, 0); chk("R10", fwd2, 0);
    idle(); ex_rs1 = 31; ex_rs2 = 30; mem_wen = 1; mem_rd = 30; wb_wen = 1; wb_rd = 31; settle();
    chk("R11", fwd1, 2); chk("R7", fwd2, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_stall();
    t_redirect();
    t_forward();
    t_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule